// File: doc/BRIEF.md
# Floating-Point Invalid-Operation Detector

This block examines up to three binary64 operands together with an operation code and reports which invalid-operation and divide-by-zero conditions the operation would raise. It is purely combinational and sits beside a floating-point datapath. The flags it produces can be merged into a status register while the arithmetic result is still being computed. The block computes no result, no rounding and no overflow, underflow or inexact information.

The block also classifies every operand as NaN, quiet NaN or signalling NaN. Each invalid case can be suppressed through a per-flag check-enable mask. For compares, an invalid-exception enable input selects how a signalling NaN is reported. Field widths are parameters, so the same block serves a binary32 datapath with `EXP_W=8, FRAC_W=23`.

Top module: `fpinv_detect`

## Requirements
- R1: An operand is a NaN when its exponent field is all ones and its fraction is nonzero. It is a quiet NaN when the top fraction bit (bit 51 for binary64) is set, and a signalling NaN otherwise. `nan_o`, `qnan_o` and `snan_o` report this with bit 0 for `opa_i`, bit 1 for `opb_i` and bit 2 for `opc_i`.
- R2: For add (op 0) and subtract (op 1), flag bit 0 (signalling NaN) rises when `opa_i` or `opb_i` is a signalling NaN. Flag bit 1 (inf-minus-inf) rises when both are infinite, with differing signs for add and with equal signs for subtract.
- R3: For multiply (op 2), flag bit 0 follows `opa_i`/`opb_i` as in R2. Flag bit 4 (inf-times-zero) rises when one multiplicand is zero and the other is infinite, in either order.
- R4: For divide (op 3), flag bit 0 follows `opa_i`/`opb_i` as in R2. Flag bit 2 (inf-over-inf) rises when both operands are infinite, and flag bit 3 (zero-over-zero) rises when both are zero.
- R5: For divide, a finite nonzero dividend `opa_i` with a zero divisor `opb_i` makes the flags exactly bit 8 (divide-by-zero), or all zero when enable bit 8 is clear. This replaces any other flag.
- R6: For multiply-add (op 4) and multiply-subtract (op 5), flag bit 0 rises for a signalling NaN in any of the three operands, and flag bit 4 follows R3 on `opa_i`/`opb_i`. The product counts as infinite when either multiplicand is infinite and neither is zero or NaN, and its sign is the XOR of the multiplicand signs. Flag bit 1 rises when that product and `opc_i` are both infinite, with differing signs for op 4 and equal signs for op 5.
- R7: For square root (op 6), flag bit 0 rises when `opa_i` is a signalling NaN, and flag bit 6 (negative root) rises when the sign bit of `opa_i` is set.
- R8: For unordered compare (op 7) and ordered compare (op 8), a signalling NaN in `opa_i` or `opb_i` raises flag bit 0. For op 8 it also raises flag bit 5 (invalid compare) when `inv_en_i` is low. Without a signalling NaN, op 8 raises flag bit 5 when either operand is a quiet NaN.
- R9: For convert-to-integer (op 9), flag bit 7 (invalid convert) rises when `opa_i` is a NaN or infinite. A signalling NaN also raises flag bit 0. Flag bit 7 never rises for any other op.
- R10: A flag bit whose `chk_en_i` bit is clear is never reported.
- R11: Op codes 10 to 15 report no flags. An operand that the selected op does not use (for example `opc_i` under add) has no effect on the flags.
- R12: All outputs follow the inputs combinationally, with no clock or state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opa_i | input | 64 | First operand (dividend, multiplicand, root/convert source) |
| opb_i | input | 64 | Second operand |
| opc_i | input | 64 | Addend for multiply-add/subtract |
| op_i | input | 4 | Operation code |
| chk_en_i | input | 9 | Per-flag check enable |
| inv_en_i | input | 1 | Invalid-exception enable, used by ordered compare |
| flags_o | output | 9 | Raised flags (bit positions as in the requirements) |
| nan_o | output | 3 | Per-operand NaN indication |
| qnan_o | output | 3 | Per-operand quiet-NaN indication |
| snan_o | output | 3 | Per-operand signalling-NaN indication |

## Verification
Every result of this block is due in the same cycle as its stimulus, because no register lies between an input and an output. The bench changes the inputs just after a rising clock edge and compares flags and classification bits at the following falling edge. The outputs have settled long before that point, and no edge races with the stimulus. Directed cases cover each sign rule, the divide-by-zero override and the compare enable. A fixed-seed random mix of special operand classes is compared against reference functions written from the requirements.

// File: rtl/fpinv_pkg.sv
package fpinv_pkg;
   localparam int FLAG_W = 9;
   localparam int F_SNAN = 0;
   localparam int F_ISI  = 1;
   localparam int F_IDI  = 2;
   localparam int F_ZDZ  = 3;
   localparam int F_IMZ  = 4;
   localparam int F_VCMP = 5;
   localparam int F_SQRT = 6;
   localparam int F_CVT  = 7;
   localparam int F_ZDIV = 8;

   typedef enum logic [3:0] {
      OP_ADD   = 4'd0,
      OP_SUB   = 4'd1,
      OP_MUL   = 4'd2,
      OP_DIV   = 4'd3,
      OP_FMADD = 4'd4,
      OP_FMSUB = 4'd5,
      OP_SQRT  = 4'd6,
      OP_CMPU  = 4'd7,
      OP_CMPO  = 4'd8,
      OP_CVT   = 4'd9
   } fpinv_op_e;

   typedef struct packed {
      logic sign;
      logic zero;
      logic inf;
      logic nan;
      logic qnan;
      logic snan;
   } fpinv_class_t;
endpackage

// File: rtl/fpinv_classify.sv
module fpinv_classify
   import fpinv_pkg::*;
#(
   parameter int EXP_W  = 11,
   parameter int FRAC_W = 52
) (
   input  logic [EXP_W+FRAC_W:0] val_i,
   output fpinv_class_t          cls_o
);
   localparam int SIGN_POS = EXP_W + FRAC_W;

   if (EXP_W < 2) begin : g_bad_exp
      $error("fpinv_classify: EXP_W must be at least 2");
   end
   if (FRAC_W < 2) begin : g_bad_frac
      $error("fpinv_classify: FRAC_W must be at least 2");
   end

   logic [EXP_W-1:0]  expf;
   logic [FRAC_W-1:0] frac;
   logic              exp_max;
   logic              frac_nz;

   assign expf = val_i[SIGN_POS-1 -: EXP_W];
   assign frac = val_i[FRAC_W-1:0];

   always_comb begin
      exp_max    = &expf;
      frac_nz    = |frac;
      cls_o.sign = val_i[SIGN_POS];
      cls_o.zero = ~(|expf) & ~frac_nz;
      cls_o.inf  = exp_max & ~frac_nz;
      cls_o.nan  = exp_max & frac_nz;
      cls_o.qnan = exp_max & frac_nz & frac[FRAC_W-1];
      cls_o.snan = exp_max & frac_nz & ~frac[FRAC_W-1];
   end

   // R1: a NaN is exactly one of quiet or signalling, and never infinite or zero
   always_comb begin
      if (cls_o.nan) begin
         assert_nan_kind_R1: assert (cls_o.qnan != cls_o.snan && !cls_o.inf && !cls_o.zero)
            else $error("NaN kind inconsistent");
      end
   end
endmodule

// File: rtl/fpinv_pair.sv
module fpinv_pair
   import fpinv_pkg::*;
(
   input  fpinv_class_t x_i,
   input  fpinv_class_t y_i,
   input  logic         chk_isi_i,
   input  logic         chk_idi_i,
   input  logic         chk_zdz_i,
   input  logic         chk_imz_i,
   input  logic         neg_i,
   output logic         isi_o,
   output logic         idi_o,
   output logic         zdz_o,
   output logic         imz_o
);
   logic both_inf;
   logic same_sign;

   always_comb begin
      both_inf  = x_i.inf & y_i.inf;
      same_sign = (x_i.sign == y_i.sign);
      isi_o     = chk_isi_i & both_inf & (neg_i ? same_sign : ~same_sign);
      idi_o     = chk_idi_i & both_inf;
      zdz_o     = chk_zdz_i & x_i.zero & y_i.zero;
      imz_o     = chk_imz_i & ((x_i.zero & y_i.inf) | (x_i.inf & y_i.zero));
   end

   // R2: the inf-minus-inf hit needs two infinite operands with the sign rule met
   always_comb begin
      if (isi_o) begin
         assert_isi_inf_R2: assert (x_i.inf && y_i.inf &&
                                    ((x_i.sign == y_i.sign) == neg_i))
            else $error("inf-inf raised without matching infinities");
      end
   end
endmodule

// File: rtl/fpinv_detect.sv
module fpinv_detect
   import fpinv_pkg::*;
#(
   parameter int EXP_W          = 11,
   parameter int FRAC_W         = 52,
   parameter bit PROD_NAN_BLOCK = 1'b1
) (
   input  logic [EXP_W+FRAC_W:0] opa_i,
   input  logic [EXP_W+FRAC_W:0] opb_i,
   input  logic [EXP_W+FRAC_W:0] opc_i,
   input  logic [3:0]            op_i,
   input  logic [FLAG_W-1:0]     chk_en_i,
   input  logic                  inv_en_i,
   output logic [FLAG_W-1:0]     flags_o,
   output logic [2:0]            nan_o,
   output logic [2:0]            qnan_o,
   output logic [2:0]            snan_o
);
   localparam int W      = 1 + EXP_W + FRAC_W;
   localparam int N_OPND = 3;
   localparam logic [FLAG_W-1:0] ZDIV_BIT = FLAG_W'(1) << F_ZDIV;

   logic [W-1:0]  opnd [N_OPND];
   fpinv_class_t  cls  [N_OPND];
   fpinv_class_t  prod;

   assign opnd[0] = opa_i;
   assign opnd[1] = opb_i;
   assign opnd[2] = opc_i;

   for (genvar i = 0; i < N_OPND; i++) begin : g_cls
      fpinv_classify #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_cls (
         .val_i (opnd[i]),
         .cls_o (cls[i])
      );
      assign nan_o[i]  = cls[i].nan;
      assign qnan_o[i] = cls[i].qnan;
      assign snan_o[i] = cls[i].snan;
   end

   // Product class for multiply-add, derived without a multiplier
   logic prod_inf_base;
   assign prod_inf_base = (cls[0].inf | cls[1].inf) & ~cls[0].zero & ~cls[1].zero;

   if (PROD_NAN_BLOCK) begin : g_prod_nanblk
      assign prod.inf = prod_inf_base & ~cls[0].nan & ~cls[1].nan;
   end else begin : g_prod_plain
      assign prod.inf = prod_inf_base;
   end
   assign prod.sign = cls[0].sign ^ cls[1].sign;
   assign prod.zero = 1'b0;
   assign prod.nan  = 1'b0;
   assign prod.qnan = 1'b0;
   assign prod.snan = 1'b0;

   // Operation decode
   logic [N_OPND-1:0] snan_sel;
   logic en_isi_ab, en_idi, en_zdz, en_imz, neg_ab;
   logic en_isi_pc, neg_pc;
   logic is_div, is_sqrt, is_cmp, is_ord, is_cvt;

   always_comb begin
      snan_sel  = '0;
      en_isi_ab = 1'b0;
      en_idi    = 1'b0;
      en_zdz    = 1'b0;
      en_imz    = 1'b0;
      neg_ab    = 1'b0;
      en_isi_pc = 1'b0;
      neg_pc    = 1'b0;
      is_div    = 1'b0;
      is_sqrt   = 1'b0;
      is_cmp    = 1'b0;
      is_ord    = 1'b0;
      is_cvt    = 1'b0;
      case (op_i)
         OP_ADD:   begin snan_sel = 3'b011; en_isi_ab = 1'b1; end
         OP_SUB:   begin snan_sel = 3'b011; en_isi_ab = 1'b1; neg_ab = 1'b1; end
         OP_MUL:   begin snan_sel = 3'b011; en_imz = 1'b1; end
         OP_DIV:   begin snan_sel = 3'b011; en_idi = 1'b1; en_zdz = 1'b1; is_div = 1'b1; end
         OP_FMADD: begin snan_sel = 3'b111; en_imz = 1'b1; en_isi_pc = 1'b1; end
         OP_FMSUB: begin snan_sel = 3'b111; en_imz = 1'b1; en_isi_pc = 1'b1; neg_pc = 1'b1; end
         OP_SQRT:  begin snan_sel = 3'b001; is_sqrt = 1'b1; end
         OP_CMPU:  begin snan_sel = 3'b011; is_cmp = 1'b1; end
         OP_CMPO:  begin snan_sel = 3'b011; is_cmp = 1'b1; is_ord = 1'b1; end
         OP_CVT:   begin snan_sel = 3'b001; is_cvt = 1'b1; end
         default:  ;
      endcase
   end

   logic isi_ab, idi_ab, zdz_ab, imz_ab;
   logic isi_pc, idi_pc, zdz_pc, imz_pc;

   fpinv_pair u_pair_ab (
      .x_i       (cls[0]),
      .y_i       (cls[1]),
      .chk_isi_i (en_isi_ab),
      .chk_idi_i (en_idi),
      .chk_zdz_i (en_zdz),
      .chk_imz_i (en_imz),
      .neg_i     (neg_ab),
      .isi_o     (isi_ab),
      .idi_o     (idi_ab),
      .zdz_o     (zdz_ab),
      .imz_o     (imz_ab)
   );

   fpinv_pair u_pair_pc (
      .x_i       (prod),
      .y_i       (cls[2]),
      .chk_isi_i (en_isi_pc),
      .chk_idi_i (1'b0),
      .chk_zdz_i (1'b0),
      .chk_imz_i (1'b0),
      .neg_i     (neg_pc),
      .isi_o     (isi_pc),
      .idi_o     (idi_pc),
      .zdz_o     (zdz_pc),
      .imz_o     (imz_pc)
   );

   logic [N_OPND-1:0] snan_vec;
   logic              snan_hit;
   logic              qnan_ab;
   logic              zdiv_cond;
   logic [FLAG_W-1:0] raw;

   always_comb begin
      for (int k = 0; k < N_OPND; k++) begin
         snan_vec[k] = cls[k].snan;
      end
      snan_hit  = |(snan_vec & snan_sel);
      qnan_ab   = cls[0].qnan | cls[1].qnan;
      zdiv_cond = is_div & ~cls[0].nan & ~cls[0].inf & ~cls[0].zero & cls[1].zero;

      raw         = '0;
      raw[F_SNAN] = snan_hit;
      raw[F_ISI]  = isi_ab | isi_pc;
      raw[F_IDI]  = idi_ab | idi_pc;
      raw[F_ZDZ]  = zdz_ab | zdz_pc;
      raw[F_IMZ]  = imz_ab | imz_pc;
      raw[F_SQRT] = is_sqrt & cls[0].sign;
      raw[F_CVT]  = is_cvt & (cls[0].nan | cls[0].inf);
      if (is_ord) begin
         raw[F_VCMP] = snan_hit ? ~inv_en_i : qnan_ab;
      end

      if (zdiv_cond) begin
         flags_o = chk_en_i & ZDIV_BIT;
      end else begin
         flags_o = raw & chk_en_i;
      end
   end

   // Checks on the assembled output
   always_comb begin
      if (zdiv_cond) begin
         assert_zdiv_alone_R5: assert ((flags_o & ~ZDIV_BIT) == '0)
            else $error("divide-by-zero not exclusive");
      end
      if (flags_o[F_CVT]) begin
         assert_cvt_only_R9: assert (op_i == OP_CVT)
            else $error("convert flag outside convert");
      end
      assert_mask_R10: assert ((flags_o & ~chk_en_i) == '0)
         else $error("disabled flag reported");
      if (op_i > OP_CVT) begin
         assert_unused_op_R11: assert (flags_o == '0)
            else $error("flags on unused op code");
      end
      if (flags_o[F_VCMP]) begin
         assert_vcmp_nan_R8: assert (op_i == OP_CMPO && (nan_o[0] || nan_o[1]))
            else $error("invalid compare without NaN");
      end
   end
endmodule

// File: tb/fpinv_detect_tb.sv
module fpinv_detect_tb_top;
   localparam time TCLK = 4ns;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [63:0] a, b, c;
   logic [3:0]  op;
   logic [8:0]  en;
   logic        inv;
   logic [8:0]  flags;
   logic [2:0]  nanv, qnanv, snanv;

   int checks = 0;
   int fails  = 0;
   bit done   = 0;

   localparam logic [63:0] PINF = 64'h7ff0000000000000;
   localparam logic [63:0] NINF = 64'hfff0000000000000;
   localparam logic [63:0] PZ   = 64'h0000000000000000;
   localparam logic [63:0] NZ   = 64'h8000000000000000;
   localparam logic [63:0] ONE  = 64'h3ff0000000000000;
   localparam logic [63:0] NONE = 64'hbff0000000000000;
   localparam logic [63:0] TWO  = 64'h4000000000000000;
   localparam logic [63:0] NTWO = 64'hc000000000000000;
   localparam logic [63:0] QN   = 64'h7ff8000000000000;
   localparam logic [63:0] SN   = 64'h7ff0000000000001;
   localparam logic [63:0] NSN  = 64'hfff4000000000000;

   always #(TCLK/2) clk = ~clk;

   fpinv_detect dut_i (
      .opa_i    (a),
      .opb_i    (b),
      .opc_i    (c),
      .op_i     (op),
      .chk_en_i (en),
      .inv_en_i (inv),
      .flags_o  (flags),
      .nan_o    (nanv),
      .qnan_o   (qnanv),
      .snan_o   (snanv)
   );

   function automatic bit r_nan(input logic [63:0] x);
      return (x[62:52] == 11'h7ff) && (x[51:0] != 0);
   endfunction
   function automatic bit r_q(input logic [63:0] x);
      return r_nan(x) && x[51];
   endfunction
   function automatic bit r_s(input logic [63:0] x);
      return r_nan(x) && !x[51];
   endfunction
   function automatic bit r_inf(input logic [63:0] x);
      return (x[62:52] == 11'h7ff) && (x[51:0] == 0);
   endfunction
   function automatic bit r_zero(input logic [63:0] x);
      return x[62:0] == 0;
   endfunction

   function automatic logic [8:0] ref_flags(input logic [3:0] o, input logic [63:0] x,
                                            input logic [63:0] y, input logic [63:0] z,
                                            input logic iv, input logic [8:0] m);
      logic [8:0] f = '0;
      bit pinf, ps;
      case (o)
         4'd0, 4'd1: begin
            if (r_s(x) || r_s(y)) f[0] = 1;
            if (r_inf(x) && r_inf(y) && ((o == 4'd1) == (x[63] == y[63]))) f[1] = 1;
         end
         4'd2: begin
            if (r_s(x) || r_s(y)) f[0] = 1;
            if ((r_zero(x) && r_inf(y)) || (r_inf(x) && r_zero(y))) f[4] = 1;
         end
         4'd3: begin
            if (!r_nan(x) && !r_inf(x) && !r_zero(x) && r_zero(y))
               return {m[8], 8'b0};
            if (r_s(x) || r_s(y)) f[0] = 1;
            if (r_inf(x) && r_inf(y)) f[2] = 1;
            if (r_zero(x) && r_zero(y)) f[3] = 1;
         end
         4'd4, 4'd5: begin
            if (r_s(x) || r_s(y) || r_s(z)) f[0] = 1;
            if ((r_zero(x) && r_inf(y)) || (r_inf(x) && r_zero(y))) f[4] = 1;
            pinf = (r_inf(x) || r_inf(y)) && !r_zero(x) && !r_zero(y) && !r_nan(x) && !r_nan(y);
            ps = x[63] ^ y[63];
            if (pinf && r_inf(z) && ((o == 4'd5) == (ps == z[63]))) f[1] = 1;
         end
         4'd6: begin
            if (r_s(x)) f[0] = 1;
            if (x[63]) f[6] = 1;
         end
         4'd7, 4'd8: begin
            if (r_s(x) || r_s(y)) begin
               f[0] = 1;
               if (o == 4'd8 && !iv) f[5] = 1;
            end else if (o == 4'd8 && (r_q(x) || r_q(y))) f[5] = 1;
         end
         4'd9: begin
            if (r_nan(x) || r_inf(x)) f[7] = 1;
            if (r_s(x)) f[0] = 1;
         end
         default: ;
      endcase
      return f & m;
   endfunction

   task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
      checks++;
      if (got !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", tag, got, exp);
      end
   endtask

   task automatic drive(input logic [3:0] o, input logic [63:0] x, input logic [63:0] y,
                        input logic [63:0] z, input logic iv, input logic [8:0] m);
      @(posedge clk);
      #1;
      op = o; a = x; b = y; c = z; inv = iv; en = m;
      @(negedge clk);
   endtask

   task automatic dir(input string tag, input logic [3:0] o, input logic [63:0] x,
                      input logic [63:0] y, input logic [63:0] z, input logic iv,
                      input logic [8:0] m, input logic [8:0] exp);
      drive(o, x, y, z, iv, m);
      chk(tag, {23'b0, flags}, {23'b0, exp});
   endtask

   function automatic logic [63:0] gen_opnd(input int unsigned kind, input int unsigned r1,
                                            input int unsigned r2);
      logic        s = r1[31];
      logic [51:0] fr = {r1[19:0], r2};
      case (kind % 7)
         0: return {s, 63'b0};
         1: return {s, 11'h7ff, 52'b0};
         2: return {s, 11'h7ff, 1'b1, fr[50:0]};
         3: return {s, 11'h7ff, 1'b0, fr[50:1], 1'b1};
         4: return {s, 11'h000, fr[51:1], 1'b1};
         default: return {s, (r1[30:20] == 11'h7ff || r1[30:20] == 0) ? 11'h400 : r1[30:20], fr};
      endcase
   endfunction

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   endtask

   initial begin
      #(TCLK * 150000);
      fails++;
      $display("FAIL watchdog R12 actual=timeout expected=completion");
      finish_run();
   end

   initial begin
      logic [8:0] all;
      all = 9'h1ff;
      op = 4'd0; a = ONE; b = ONE; c = ONE; inv = 1'b0; en = all;
      repeat (3) @(posedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R12 idle flags", {23'b0, flags}, 32'h0);
      chk("R1 idle class", {23'b0, nanv, qnanv, snanv}, 32'h0);

      // R1 classification
      drive(4'd0, QN, SN, ONE, 1'b0, all);
      chk("R1 nan", {29'b0, nanv}, 32'h3);
      chk("R1 qnan", {29'b0, qnanv}, 32'h1);
      chk("R1 snan", {29'b0, snanv}, 32'h2);
      drive(4'd0, ONE, PINF, NSN, 1'b0, all);
      chk("R1 nan c", {29'b0, nanv}, 32'h4);
      chk("R1 snan c", {29'b0, snanv}, 32'h4);

      // R2 add / subtract
      dir("R2 add +inf-inf", 4'd0, PINF, NINF, PZ, 0, all, 9'h002);
      dir("R2 add +inf+inf", 4'd0, PINF, PINF, PZ, 0, all, 9'h000);
      dir("R2 sub inf-inf",  4'd1, PINF, PINF, PZ, 0, all, 9'h002);
      dir("R2 sub inf--inf", 4'd1, PINF, NINF, PZ, 0, all, 9'h000);
      dir("R2 add snan",     4'd0, SN, ONE, PZ, 0, all, 9'h001);
      // R11 opc unused under add
      dir("R11 add ignores opc", 4'd0, ONE, ONE, SN, 0, all, 9'h000);
      dir("R11 op12 no flags",   4'd12, SN, SN, SN, 0, all, 9'h000);
      dir("R11 op15 no flags",   4'd15, PINF, NINF, PZ, 0, all, 9'h000);

      // R3 multiply
      dir("R3 mul 0*inf",  4'd2, PZ, PINF, PZ, 0, all, 9'h010);
      dir("R3 mul inf*-0", 4'd2, NINF, NZ, PZ, 0, all, 9'h010);
      dir("R3 mul inf*inf",4'd2, PINF, NINF, PZ, 0, all, 9'h000);

      // R4 / R5 divide
      dir("R4 div inf/inf", 4'd3, PINF, NINF, PZ, 0, all, 9'h004);
      dir("R4 div 0/0",     4'd3, PZ, NZ, PZ, 0, all, 9'h008);
      dir("R4 div snan/0",  4'd3, SN, PZ, PZ, 0, all, 9'h001);
      dir("R4 div inf/0",   4'd3, PINF, PZ, PZ, 0, all, 9'h000);
      dir("R5 div 1/0",     4'd3, ONE, PZ, PZ, 0, all, 9'h100);
      dir("R5 div -2/-0",   4'd3, NTWO, NZ, PZ, 0, all, 9'h100);
      dir("R5 div 1/0 masked", 4'd3, ONE, PZ, PZ, 0, 9'h0ff, 9'h000);

      // R6 multiply-add / subtract
      dir("R6 fmadd inf*2+-inf", 4'd4, PINF, TWO, NINF, 0, all, 9'h002);
      dir("R6 fmadd -inf*-inf",  4'd4, PINF, NTWO, NINF, 0, all, 9'h000);
      dir("R6 fmsub inf*2-inf",  4'd5, PINF, TWO, PINF, 0, all, 9'h002);
      dir("R6 fmadd 0*inf+1",    4'd4, PZ, PINF, ONE, 0, all, 9'h010);
      dir("R6 fmadd inf*qnan",   4'd4, PINF, QN, NINF, 0, all, 9'h000);
      dir("R6 fmadd snan c",     4'd4, ONE, ONE, SN, 0, all, 9'h001);

      // R7 square root
      dir("R7 sqrt -1",   4'd6, NONE, PZ, PZ, 0, all, 9'h040);
      dir("R7 sqrt -0",   4'd6, NZ, PZ, PZ, 0, all, 9'h040);
      dir("R7 sqrt snan", 4'd6, SN, PZ, PZ, 0, all, 9'h001);
      dir("R7 sqrt -snan",4'd6, NSN, PZ, PZ, 0, all, 9'h041);
      dir("R7 sqrt 1",    4'd6, ONE, SN, SN, 0, all, 9'h000);

      // R8 compare
      dir("R8 cmpu snan",      4'd7, SN, ONE, PZ, 0, all, 9'h001);
      dir("R8 cmpo snan inv0", 4'd8, ONE, SN, PZ, 0, all, 9'h021);
      dir("R8 cmpo snan inv1", 4'd8, SN, ONE, PZ, 1, all, 9'h001);
      dir("R8 cmpo qnan",      4'd8, QN, ONE, PZ, 1, all, 9'h020);
      dir("R8 cmpu qnan",      4'd7, QN, ONE, PZ, 0, all, 9'h000);

      // R9 convert
      dir("R9 cvt inf",  4'd9, PINF, PZ, PZ, 0, all, 9'h080);
      dir("R9 cvt -inf", 4'd9, NINF, PZ, PZ, 0, all, 9'h080);
      dir("R9 cvt snan", 4'd9, SN, PZ, PZ, 0, all, 9'h081);
      dir("R9 cvt qnan", 4'd9, QN, PZ, PZ, 0, all, 9'h080);
      dir("R9 cvt one",  4'd9, ONE, SN, SN, 0, all, 9'h000);

      // R10 masking
      dir("R10 add isi masked", 4'd0, PINF, NINF, PZ, 0, 9'h1fd, 9'h000);
      dir("R10 cvt snan partial", 4'd9, SN, PZ, PZ, 0, 9'h0fe, 9'h080);

      // Random mix
      begin
         int unsigned seed_v;
         seed_v = $urandom(32'h5eed_0097);
         for (int it = 0; it < 4000; it++) begin
            logic [63:0] x, y, z;
            logic [3:0]  o;
            logic [8:0]  m;
            logic        iv;
            x  = gen_opnd($urandom, $urandom, $urandom);
            y  = gen_opnd($urandom, $urandom, $urandom);
            z  = gen_opnd($urandom, $urandom, $urandom);
            o  = 4'($urandom % 16);
            m  = ($urandom % 4 == 0) ? 9'($urandom) : 9'h1ff;
            iv = 1'($urandom);
            drive(o, x, y, z, iv, m);
            chk("R2-9 random flags", {23'b0, flags}, {23'b0, ref_flags(o, x, y, z, iv, m)});
            chk("R1 random class", {23'b0, nanv, qnanv, snanv},
                {23'b0, r_nan(z), r_nan(y), r_nan(x), r_q(z), r_q(y), r_q(x),
                 r_s(z), r_s(y), r_s(x)});
         end
      end

      finish_run();
   end
endmodule